// File: doc/BRIEF.md
# Manchester Serial Word Encoder

This block turns one parallel data word into one self-clocked serial frame on a differential pair. Each frame is 20 bit times long. It opens with a 3-bit-time sync pattern that is not Manchester coded. The sync polarity marks the word as a command word or a data word. Sixteen Manchester-coded data bits follow, most significant bit first, and then an odd-parity bit. The encoder advances on a single-cycle enable pulse, `half_tick`, which arrives at twice the bit rate. A frame therefore spans 40 half-bit slots, numbered 0 to 39. Slots 0–5 hold the sync, slot pair 6+2i holds data bit 15−i, and slots 38–39 hold the parity bit.

A frame starts when a `half_tick` arrives while `enc_req` is high and the encoder is idle. The sync type is sampled at that same tick. Partway through the sync, `load_stb` tells the source when the data word is taken. After the parity bit, `cycle_done` pulses for one clock. If `enc_req` is still high at that moment, the next frame follows with no gap.

Top module: `mse_encoder`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `line_pos` and `line_neg` are both low, and `load_stb` and `cycle_done` are low.
- R2: A frame starts only on a clock where `half_tick` and `enc_req` are both high while idle. The frame then occupies exactly 40 slots, and the line outputs change only on clocks with `half_tick` high.
- R3: With `sync_is_cmd`=1 at the start tick, `line_pos` is high in slots 0–2 and low in slots 3–5. With 0 the levels are inverted. Changes to `sync_is_cmd` after the start tick do not affect the running frame.
- R4: Data bit 15−i is sent in slots 6+2i and 7+2i. A 1 is high then low on `line_pos`, and a 0 is low then high.
- R5: Slots 38–39 carry a parity bit coded like a data bit. Its value makes the number of ones among the 16 data bits plus parity odd.
- R6: During a frame, `line_neg` is the complement of `line_pos`.
- R7: `load_stb` is high in slots 3 and 4 only. `word_in` is sampled on the `half_tick` that ends slot 4, and its value at any other time has no effect on the frame.
- R8: `cycle_done` is high for exactly one clock: the clock after the `half_tick` that ends slot 39.
- R9: If `enc_req` is high at the tick that ends slot 39, the next frame's slot 0 begins at that tick, using the sync type sampled then. Otherwise both lines return low.
- R10: A synchronous active-high `rst` aborts any frame and restores the R1 state on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Single-cycle enable at twice the bit rate |
| enc_req | input | 1 | Request to send a word |
| sync_is_cmd | input | 1 | Sync select: 1 command sync, 0 data sync |
| word_in | input | 16 | Parallel data word |
| line_pos | output | 1 | True serial line |
| line_neg | output | 1 | Complement serial line |
| load_stb | output | 1 | High while the data word is about to be taken |
| cycle_done | output | 1 | One-clock pulse after the parity bit ends |

## Verification
Two functions can fall on the same clock: the end-of-frame pulse and the start of the next frame. Both happen at the tick that ends slot 39. The bench provokes this by keeping `enc_req` high through chained frames and by flipping `sync_is_cmd` just before that tick. It then checks that `cycle_done` is high in the same sampled cycle in which the lines already show the new frame's slot 0, with the new sync polarity. It also checks that `cycle_done` drops one clock later while the new frame continues.

// File: rtl/mse_pkg.sv
package mse_pkg;

    typedef enum logic {
        SYNC_DATA = 1'b0,
        SYNC_CMD  = 1'b1
    } sync_kind_e;

    // Level of the true line during the sync field.
    function automatic logic sync_level(sync_kind_e kind, logic first_part);
        return (kind == SYNC_CMD) ? first_part : ~first_part;
    endfunction

    // Odd-parity bit over a word of any width up to 64.
    function automatic logic odd_parity(logic [63:0] word);
        return ~(^word);
    endfunction

endpackage

// File: rtl/mse_slot_timer.sv
module mse_slot_timer
    import mse_pkg::*;
#(
    parameter int SYNC_HALVES  = 6,
    parameter int FRAME_HALVES = 40,
    parameter int LOAD_SLOT    = 4,
    parameter int CNT_W        = $clog2(FRAME_HALVES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_tick,
    input  logic             enc_req,
    input  logic             sync_is_cmd,
    output logic             act,
    output logic [CNT_W-1:0] slot,
    output sync_kind_e       kind,
    output logic             load_win,
    output logic             capture,
    output logic             cycle_done
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_HALVES - 1);
    localparam logic [CNT_W-1:0] CAP_SLOT  = CNT_W'(LOAD_SLOT);
    localparam logic [CNT_W-1:0] WIN_SLOT  = CNT_W'(LOAD_SLOT - 1);

    logic frame_end;
    assign frame_end = act && (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            act        <= 1'b0;
            slot       <= '0;
            kind       <= SYNC_DATA;
            cycle_done <= 1'b0;
        end else begin
            cycle_done <= 1'b0;
            if (half_tick) begin
                if (!act || frame_end) begin
                    cycle_done <= frame_end;
                    slot       <= '0;
                    if (enc_req) begin
                        act  <= 1'b1;
                        kind <= sync_is_cmd ? SYNC_CMD : SYNC_DATA;
                    end else begin
                        act <= 1'b0;
                    end
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    assign load_win = act && ((slot == WIN_SLOT) || (slot == CAP_SLOT));
    assign capture  = half_tick && act && (slot == CAP_SLOT);

    a_r2_slot_advance: assert property (@(posedge clk) disable iff (rst)
        (half_tick && act && slot != LAST_SLOT) |=> (act && slot == $past(slot) + 1'b1));
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!half_tick) |=> ($stable(slot) && $stable(act) && $stable(kind)));
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> ($past(slot) == LAST_SLOT && $past(half_tick)));
    a_r9_chain_restart: assert property (@(posedge clk) disable iff (rst)
        (half_tick && frame_end && enc_req) |=> (act && slot == '0 && cycle_done));

endmodule

// File: rtl/mse_word_reg.sv
module mse_word_reg
    import mse_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] data_q,
    output logic              par_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            par_q  <= 1'b0;
        end else if (capture) begin
            data_q <= word_in;
            par_q  <= odd_parity(64'(word_in));
        end
    end

    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        capture |=> (data_q == $past(word_in)));
    a_r5_odd_parity: assert property (@(posedge clk) disable iff (rst)
        capture |=> (($countones({data_q, par_q}) % 2) == 1));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(data_q) && $stable(par_q)));

endmodule

// File: rtl/mse_line_drv.sv
module mse_line_drv
    import mse_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_HALVES = 6,
    parameter int CNT_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              act,
    input  logic [CNT_W-1:0]  slot,
    input  sync_kind_e        kind,
    input  logic [DATA_W-1:0] data_q,
    input  logic              par_q,
    output logic              line_pos,
    output logic              line_neg
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] SYNC_END  = CNT_W'(SYNC_HALVES);
    localparam logic [CNT_W-1:0] SYNC_MID  = CNT_W'(SYNC_HALVES / 2);
    localparam logic [CNT_W-1:0] DATA_CNT  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TOP_INDEX = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] bit_pos;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;
    logic             level;

    always_comb begin
        rel     = slot - SYNC_END;
        bit_pos = rel >> 1;
        bit_idx = IDX_W'(TOP_INDEX - bit_pos);
        bit_val = (bit_pos < DATA_CNT) ? data_q[bit_idx] : par_q;
        if (slot < SYNC_END) begin
            level = sync_level(kind, slot < SYNC_MID);
        end else begin
            level = rel[0] ? ~bit_val : bit_val;
        end
    end

    assign line_pos = act & level;
    assign line_neg = act & ~level;

    a_r6_complement: assert property (@(posedge clk) disable iff (rst)
        act |-> (line_pos != line_neg));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !act |-> (!line_pos && !line_neg));
    a_r4_mid_bit_edge: assert property (@(posedge clk) disable iff (rst)
        (half_tick && act && slot >= SYNC_END && !rel[0]) |=> (line_pos != $past(line_pos)));

endmodule

// File: rtl/mse_encoder.sv
module mse_encoder
    import mse_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SYNC_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              enc_req,
    input  logic              sync_is_cmd,
    input  logic [DATA_W-1:0] word_in,
    output logic              line_pos,
    output logic              line_neg,
    output logic              load_stb,
    output logic              cycle_done
);
    localparam int SYNC_HALVES  = 2 * SYNC_BITS;
    localparam int FRAME_HALVES = SYNC_HALVES + 2 * (DATA_W + 1);
    localparam int CNT_W        = $clog2(FRAME_HALVES);
    localparam int LOAD_SLOT    = SYNC_HALVES - 2;

    logic             act;
    logic [CNT_W-1:0] slot;
    sync_kind_e       kind;
    logic             capture;
    logic [DATA_W-1:0] data_q;
    logic             par_q;

    mse_slot_timer #(
        .SYNC_HALVES (SYNC_HALVES),
        .FRAME_HALVES(FRAME_HALVES),
        .LOAD_SLOT   (LOAD_SLOT),
        .CNT_W       (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .half_tick  (half_tick),
        .enc_req    (enc_req),
        .sync_is_cmd(sync_is_cmd),
        .act        (act),
        .slot       (slot),
        .kind       (kind),
        .load_win   (load_stb),
        .capture    (capture),
        .cycle_done (cycle_done)
    );

    mse_word_reg #(
        .DATA_W(DATA_W)
    ) word_i (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .word_in(word_in),
        .data_q (data_q),
        .par_q  (par_q)
    );

    mse_line_drv #(
        .DATA_W     (DATA_W),
        .SYNC_HALVES(SYNC_HALVES),
        .CNT_W      (CNT_W)
    ) line_i (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .act      (act),
        .slot     (slot),
        .kind     (kind),
        .data_q   (data_q),
        .par_q    (par_q),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!line_pos && !line_neg && !load_stb && !cycle_done));

endmodule

// File: tb/mse_encoder_tb.sv
module mse_encoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 5;

    typedef struct packed {
        logic        cmd;
        logic [15:0] word;
        logic        keep;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{cmd: 1'b1, word: 16'hA5C7, keep: 1'b0},
        '{cmd: 1'b0, word: 16'h0000, keep: 1'b1},
        '{cmd: 1'b1, word: 16'hFFFF, keep: 1'b1},
        '{cmd: 1'b0, word: 16'h8000, keep: 1'b0},
        '{cmd: 1'b1, word: 16'h7FFE, keep: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_tick = 1'b0;
    logic        enc_req = 1'b0;
    logic        sync_is_cmd = 1'b0;
    logic [15:0] word_in = 16'h0;
    logic        line_pos, line_neg, load_stb, cycle_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mse_encoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .half_tick  (half_tick),
        .enc_req    (enc_req),
        .sync_is_cmd(sync_is_cmd),
        .word_in    (word_in),
        .line_pos   (line_pos),
        .line_neg   (line_neg),
        .load_stb   (load_stb),
        .cycle_done (cycle_done)
    );

    function automatic logic exp_level(int s, logic cmd, logic [15:0] w);
        logic b;
        if (s < 3) return cmd;
        if (s < 6) return ~cmd;
        if (s >= 38) b = ~(^w);
        else b = w[15 - (s - 6) / 2];
        return (s % 2 == 0) ? b : ~b;
    endfunction

    task automatic check(string req, logic [3:0] act_v, logic [3:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    task automatic pulse_tick();
        repeat (2) @(negedge clk);
        half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
    endtask

    // Runs a frame already showing slot 0; ends just after the closing tick.
    task automatic run_frame(logic cmd, logic [15:0] w, logic keep, logic next_cmd);
        enc_req     = keep;
        sync_is_cmd = ~cmd;
        for (int s = 0; s < 40; s++) begin
            logic e;
            e = exp_level(s, cmd, w);
            if (s < 6)       check("R3", {2'b0, line_pos, line_neg}, {2'b0, e, ~e});
            else if (s < 38) check("R4", {2'b0, line_pos, line_neg}, {2'b0, e, ~e});
            else             check("R5", {2'b0, line_pos, line_neg}, {2'b0, e, ~e});
            check("R7", {3'b0, load_stb}, {3'b0, (s == 3 || s == 4)});
            word_in = (s == 4) ? w : ~w;
            if (s == 39) sync_is_cmd = next_cmd;
            pulse_tick();
        end
        check("R8", {3'b0, cycle_done}, 4'b0001);
        if (!keep) check("R9", {2'b0, line_pos, line_neg}, 4'b0000);
        else check("R9", {2'b0, line_pos, line_neg}, {2'b0, next_cmd, ~next_cmd});
        @(negedge clk);
        check("R8", {3'b0, cycle_done}, 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {line_pos, line_neg, load_stb, cycle_done}, 4'b0000);

        // idle ticks without request: lines stay quiet
        pulse_tick();
        pulse_tick();
        check("R2", {line_pos, line_neg, load_stb, cycle_done}, 4'b0000);

        // request without tick does not start
        enc_req = 1'b1;
        sync_is_cmd = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", {2'b0, line_pos, line_neg}, 4'b0000);
        enc_req = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic nxt;
            nxt = (i + 1 < NVEC) ? VECS[i + 1].cmd : 1'b0;
            if (i == 0 || !VECS[i - 1].keep) begin
                sync_is_cmd = VECS[i].cmd;
                enc_req = 1'b1;
                pulse_tick();
            end
            run_frame(VECS[i].cmd, VECS[i].word, VECS[i].keep, nxt);
        end

        // stable between ticks (R2): sample mid-gap after a start
        sync_is_cmd = 1'b0;
        enc_req = 1'b1;
        pulse_tick();
        enc_req = 1'b0;
        @(negedge clk);
        check("R2", {2'b0, line_pos, line_neg}, 4'b0001);

        // reset in mid-frame aborts (R10)
        pulse_tick();
        pulse_tick();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", {line_pos, line_neg, load_stb, cycle_done}, 4'b0000);
        pulse_tick();
        check("R10", {line_pos, line_neg, load_stb, cycle_done}, 4'b0000);

        // after abort a fresh frame runs normally
        sync_is_cmd = 1'b1;
        enc_req = 1'b1;
        pulse_tick();
        run_frame(1'b1, 16'h0001, 1'b0, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule